// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Slave

This block answers a three-wire serial memory bus as a word-organised EEPROM. The bus master raises chip select, clocks in a start bit, a two-bit opcode and a word address, and then either receives data words or sends one. The storage is a register array of 16-bit words. Its depth is a parameter (64, 128 or 256 words), and the address width follows from it. Every bus pin is brought into the system clock domain and sampled there. Serial clock rising edges are found by comparing the current level with the level one cycle earlier.

Reads begin with one zero bit, followed by the addressed word with the MSB first. While chip select stays high, the following words stream out back to back and the address wraps to zero at the top. Writes are locked after reset. A control command unlocks them and another locks them again. A write commits only when chip select falls in the gap between the last data bit and the next clock rise. A commit starts a self-timed programming interval, counted in system clock cycles. During that interval the bus is ignored, and the master can poll progress on the data output.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset, every word reads as 16'hFFFF, the output enable is low and writes are locked.
- R2: Opcode 2'b10 after the start bit 1 is a read. When the last address bit is clocked in, the output is enabled and carries a 0. Each of the next 16 clock rises then presents one bit of the addressed word, MSB first.
- R3: While chip select stays high after a read word, the next address follows with no extra zero bit. The address after DEPTH-1 is 0.
- R4: Opcode 2'b00 with address bits [AW-1:AW-2] = 2'b11 unlocks writes. The same opcode with those bits at 2'b00 locks them again. A write sent while writes are locked changes nothing and starts no programming interval.
- R5: Opcode 2'b01, followed by the address and 16 data bits sent MSB first, replaces the whole word once it commits. No erase step is needed.
- R6: A write commits only if chip select falls after the 16th data bit and before another clock rise. An extra clock rise, or an early fall, discards the command.
- R7: After a commit, chip select high drives the output enabled and low for about PROG_CYCLES system clocks, then enabled and high. The high level stays until chip select falls or a start bit is decoded.
- R8: Bus activity during the programming interval, including a start bit, is ignored.
- R9: The output enable is low whenever chip select is low, and while the start bit, the opcode and all but the last address bit are being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mw_cs | input | 1 | Chip select, active high |
| mw_sclk | input | 1 | Serial clock from the master |
| mw_din | input | 1 | Serial data from the master |
| mw_dout | output | 1 | Serial data or ready/busy flag to the master |
| mw_dout_oe | output | 1 | Output enable for mw_dout |

## Verification
The assertions assume that every bus level is held for several system clock cycles, so that the synchroniser and the edge detector see each serial clock phase exactly once. They also assume that chip select changes only while the serial clock is low. The stimulus changes pins only on falling edges of the system clock and holds each bus phase for four system cycles. Chip select is moved only while the serial clock is low. Under these conditions every rise is decoded once, and the programming interval is measured against a known start.

// File: rtl/mw_pkg.sv
// Shared encodings for the serial EEPROM slave.
// Assumes the 16-bit word organisation used throughout the block.
package mw_pkg;
    localparam int WORD_W = 16;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_CTRL  = 2'b00;

    localparam logic [1:0] SUB_UNLOCK = 2'b11;
    localparam logic [1:0] SUB_LOCK   = 2'b00;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_RD_OUT,
        S_WR_DATA,
        S_WR_TAIL,
        S_SINK,
        S_BUSY
    } mw_state_e;
endpackage

// File: rtl/mw_bus_sync.sv
// Brings the three bus inputs into the clk domain and derives edge pulses.
// Assumes each bus level is held for more than STAGES+1 clk cycles.
module mw_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_in,
    input  logic sclk_in,
    input  logic din_in,
    output logic cs_s,
    output logic din_s,
    output logic sclk_rise,
    output logic cs_fall
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] din_pipe;
    logic              sclk_prev;
    logic              cs_prev;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_pipe   <= '0;
            sclk_pipe <= '0;
            din_pipe  <= '0;
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b0;
        end else begin
            cs_pipe   <= {cs_pipe[STAGES-2:0], cs_in};
            sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk_in};
            din_pipe  <= {din_pipe[STAGES-2:0], din_in};
            sclk_prev <= sclk_pipe[TOP];
            cs_prev   <= cs_pipe[TOP];
        end
    end

    // Synchronised levels and single-cycle edge pulses.
    always_comb begin
        cs_s      = cs_pipe[TOP];
        din_s     = din_pipe[TOP];
        sclk_rise = sclk_pipe[TOP] & ~sclk_prev;
        cs_fall   = cs_prev & ~cs_pipe[TOP];
    end
endmodule

// File: rtl/mw_word_store.sv
// Register array of DEPTH words, one synchronous write port and one combinational read port.
// Assumes waddr and raddr are always inside the array (AW = clog2(DEPTH)).
module mw_word_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic [DW-1:0] q;

        // One word register: resets to all ones, replaced whole on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '1;
            end else if (we && (waddr == AW'(i))) begin
                q <= wdata;
            end
        end

        assign words[i] = q;
    end

    // Read port.
    assign rdata = words[raddr];
endmodule

// File: rtl/mw_prog_timer.sv
// Self-timed programming interval: busy for CYCLES clk cycles after start, then a done pulse.
// Assumes CYCLES >= 1 and no start while busy.
module mw_prog_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    // Down-counter that holds busy for the interval and pulses done at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                remain <= CW'(CYCLES);
                busy   <= 1'b1;
            end else if (busy) begin
                if (remain <= CW'(1)) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    remain <= '0;
                end else begin
                    remain <= remain - CW'(1);
                end
            end
        end
    end

    // R7: the end-of-interval pulse only ever follows a busy cycle.
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: rtl/mw_eeprom_slave.sv
// Serial EEPROM word slave: decodes start bit, opcode and address from the bus,
// streams reads, commits writes with chip-select framing and reports ready/busy.
// Assumes bus pins are slow relative to clk (see mw_bus_sync) and that DEPTH is a power of two.
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mw_cs,
    input  logic mw_sclk,
    input  logic mw_din,
    output logic mw_dout,
    output logic mw_dout_oe
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(WORD_W);

    logic              cs_s, din_s, sclk_rise, cs_fall;
    mw_state_e         state;
    logic [1:0]        opcode;
    logic [AW-1:0]     addr;
    logic [AW-1:0]     addr_next;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] mem_rdata;
    logic              wen_q;
    logic              rd_bit;
    logic              poll_q;
    logic              mem_we;
    logic              tmr_busy, tmr_done;
    logic              bit_in;

    mw_bus_sync #(.STAGES(2)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_in     (mw_cs),
        .sclk_in   (mw_sclk),
        .din_in    (mw_din),
        .cs_s      (cs_s),
        .din_s     (din_s),
        .sclk_rise (sclk_rise),
        .cs_fall   (cs_fall)
    );

    mw_word_store #(.DEPTH(DEPTH), .AW(AW), .DW(WORD_W)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr),
        .wdata (wdata),
        .raddr (addr),
        .rdata (mem_rdata)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mem_we),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    // A serial bit is accepted on a clock rise while chip select is high.
    assign bit_in    = cs_s & sclk_rise;
    assign addr_next = {addr[AW-2:0], din_s};

    // Command sequencer: framing, decode, read streaming, write commit and busy wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            opcode <= '0;
            addr   <= '0;
            cnt    <= '0;
            wdata  <= '0;
            wen_q  <= 1'b0;
            rd_bit <= 1'b0;
            poll_q <= 1'b0;
            mem_we <= 1'b0;
        end else begin
            mem_we <= 1'b0;
            if (cs_fall && state != S_BUSY && state != S_WR_TAIL) begin
                poll_q <= 1'b0;
            end
            case (state)
                S_IDLE: begin
                    if (bit_in && din_s) begin
                        state  <= S_OPC;
                        cnt    <= '0;
                        poll_q <= 1'b0;
                    end
                end
                S_OPC: begin
                    if (!cs_s) begin
                        state <= S_IDLE;
                    end else if (bit_in) begin
                        opcode <= {opcode[0], din_s};
                        if (cnt == CNT_W'(1)) begin
                            state <= S_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                S_ADDR: begin
                    if (!cs_s) begin
                        state <= S_IDLE;
                    end else if (bit_in) begin
                        addr <= addr_next;
                        if (cnt == CNT_W'(AW - 1)) begin
                            cnt <= '0;
                            case (opcode)
                                OP_READ: begin
                                    state  <= S_RD_OUT;
                                    rd_bit <= 1'b0;
                                end
                                OP_WRITE: begin
                                    state <= wen_q ? S_WR_DATA : S_SINK;
                                end
                                OP_CTRL: begin
                                    if (addr_next[AW-1 -: 2] == SUB_UNLOCK) begin
                                        wen_q <= 1'b1;
                                    end else if (addr_next[AW-1 -: 2] == SUB_LOCK) begin
                                        wen_q <= 1'b0;
                                    end
                                    state <= S_SINK;
                                end
                                default: state <= S_SINK;
                            endcase
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                S_RD_OUT: begin
                    if (!cs_s) begin
                        state <= S_IDLE;
                    end else if (bit_in) begin
                        rd_bit <= mem_rdata[~cnt];
                        if (cnt == CNT_W'(WORD_W - 1)) begin
                            addr <= addr + AW'(1);
                        end
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                S_WR_DATA: begin
                    if (!cs_s) begin
                        state <= S_IDLE;
                    end else if (bit_in) begin
                        wdata <= {wdata[WORD_W-2:0], din_s};
                        if (cnt == CNT_W'(WORD_W - 1)) begin
                            state <= S_WR_TAIL;
                        end
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                S_WR_TAIL: begin
                    if (!cs_s) begin
                        mem_we <= 1'b1;
                        poll_q <= 1'b1;
                        state  <= S_BUSY;
                    end else if (sclk_rise) begin
                        state <= S_SINK;
                    end
                end
                S_SINK: begin
                    if (!cs_s) begin
                        state <= S_IDLE;
                    end
                end
                S_BUSY: begin
                    if (tmr_done) begin
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output driver: read data while streaming, ready/busy flag while polled.
    always_comb begin
        mw_dout_oe = cs_s && ((state == S_RD_OUT) ||
                              (poll_q && (state == S_BUSY || state == S_IDLE)));
        mw_dout    = (state == S_RD_OUT) ? rd_bit : (state != S_BUSY);
    end

    // R2: the first bit presented after a read address is the zero bit.
    p_dummy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_OUT && $past(state) == S_ADDR) |-> !rd_bit);

    // R4: a commit never happens while writes are locked.
    p_we_unlocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen_q);

    // R7: a polled busy interval shows an enabled low output.
    p_status_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && cs_s) |-> (mw_dout_oe && !mw_dout));

    // R8: the sequencer decodes nothing while the timer runs.
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_busy |-> (state == S_BUSY));

    // R5: each commit is followed by the programming interval.
    p_commit_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> tmr_busy);
endmodule

// File: tb/test_mw_eeprom_slave.sv
// Self-checking bench: sweeps every word of the 64-word configuration and the framing corners.
module test_mw_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int AW         = 6;
    localparam int PROG       = 40;
    localparam int PH         = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, din = 1'b0;
    logic dout, oe;
    logic [15:0] model [DEPTH];
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mw_eeprom_slave #(.DEPTH(DEPTH), .PROG_CYCLES(PROG)) i_mw_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .mw_cs(cs), .mw_sclk(sclk), .mw_din(din),
        .mw_dout(dout), .mw_dout_oe(oe)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_ph();
        repeat (PH) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        din = b;
        wait_ph();
        sclk = 1'b1;
        wait_ph();
        sclk = 1'b0;
        wait_ph();
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic cs_to(input logic v);
        cs = v;
        wait_ph();
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'((i * 16'h0123) ^ 16'hA55A);
    endfunction

    task automatic wr_cmd(input int a, input logic [15:0] d);
        cs_to(1'b1);
        send(3'b101, 3);
        send(a, AW);
        send(d, 16);
        cs_to(1'b0);
    endtask

    task automatic ctl_cmd(input logic [1:0] sub);
        cs_to(1'b1);
        send(3'b100, 3);
        send({sub, 4'b0000}, AW);
        cs_to(1'b0);
    endtask

    // Raise chip select and count clk cycles until the ready flag appears; cs left high.
    task automatic wait_ready(output int cyc, output logic [1:0] early);
        cs = 1'b1;
        cyc = 0;
        early = 2'bxx;
        while (!(oe === 1'b1 && dout === 1'b1) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 8) early = {oe, dout};
        end
    endtask

    task automatic rd_check(input string req, input int a, input int n);
        logic [15:0] w;
        cs_to(1'b1);
        send(3'b110, 3);
        send(a, AW);
        chk(req, "zero bit before first word {oe,dout}", {oe, dout}, 2'b10);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < 16; b++) begin
                pulse(1'b0);
                w = {w[14:0], dout};
            end
            chk(req, $sformatf("word at %0d", (a + k) % DEPTH), w, model[(a + k) % DEPTH]);
        end
        cs_to(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [1:0] early;
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_ph();

        // R1 / R9: quiet output after reset and with chip select low.
        chk("R1", "oe after reset", oe, 1'b0);
        rd_check("R1", 0, 1);
        rd_check("R2", 17, 1);

        // R9: no drive during start, opcode and early address bits.
        cs_to(1'b1);
        pulse(1'b1); chk("R9", "oe after start bit", oe, 1'b0);
        pulse(1'b1); pulse(1'b0); chk("R9", "oe after opcode", oe, 1'b0);
        for (int i = 0; i < AW - 1; i++) begin
            pulse(1'b0);
            chk("R9", "oe during address", oe, 1'b0);
        end
        pulse(1'b0);
        chk("R9", "oe after last address bit", oe, 1'b1);
        cs_to(1'b0);
        chk("R9", "oe with cs low", oe, 1'b0);

        // R4: writes locked after reset.
        wr_cmd(5, 16'h1234);
        cs_to(1'b1);
        chk("R4", "no busy when locked, oe", oe, 1'b0);
        cs_to(1'b0);
        rd_check("R4", 5, 1);

        // R7: unlock, write and time the programming interval.
        ctl_cmd(2'b11);
        wr_cmd(9, 16'hBEEF);
        model[9] = 16'hBEEF;
        wait_ready(cyc, early);
        chk("R7", "busy flag {oe,dout}", early, 2'b10);
        chk("R7", "interval not shorter than PROG-3", (cyc >= PROG - 3), 1'b1);
        chk("R7", "interval not longer than PROG+4", (cyc <= PROG + 4), 1'b1);
        repeat (20) @(negedge clk);
        chk("R7", "ready flag held", {oe, dout}, 2'b11);
        cs_to(1'b0);
        chk("R7", "oe after cs fall", oe, 1'b0);
        cs_to(1'b1);
        chk("R7", "ready flag cleared by cs fall", oe, 1'b0);
        cs_to(1'b0);
        rd_check("R5", 9, 1);

        // R8: a read command during the interval is ignored.
        wr_cmd(10, 16'h0F0F);
        model[10] = 16'h0F0F;
        cs_to(1'b1);
        send(9'b110000000, 9);
        chk("R8", "status instead of read {oe,dout}", {oe, dout}, 2'b11);
        cs_to(1'b0);
        wait_ready(cyc, early);
        cs_to(1'b0);

        // R5: write every word with a computed pattern.
        for (int i = 0; i < DEPTH; i++) begin
            wr_cmd(i, pat(i));
            model[i] = pat(i);
            wait_ready(cyc, early);
            cs_to(1'b0);
        end

        // R3: stream the whole array and wrap past the top.
        rd_check("R3", 0, DEPTH + 2);
        rd_check("R3", DEPTH - 1, 3);

        // R6: extra clock after the data, then early chip-select fall.
        cs_to(1'b1);
        send(3'b101, 3); send(20, AW); send(16'h7777, 16);
        pulse(1'b0);
        cs_to(1'b0);
        cs_to(1'b1);
        chk("R6", "no busy after extra clock, oe", oe, 1'b0);
        cs_to(1'b0);
        cs_to(1'b1);
        send(3'b101, 3); send(21, AW); send(16'h3333, 15);
        cs_to(1'b0);
        cs_to(1'b1);
        chk("R6", "no busy after short data, oe", oe, 1'b0);
        cs_to(1'b0);
        rd_check("R6", 20, 2);

        // R4: lock again; a write has no effect.
        ctl_cmd(2'b00);
        wr_cmd(30, 16'h0000);
        cs_to(1'b1);
        chk("R4", "no busy after relock, oe", oe, 1'b0);
        cs_to(1'b0);
        rd_check("R4", 30, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule